// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block is the digital side of an eight-input successive-approximation converter. A small register port lets software pick which inputs take part, how far the system clock is divided for the converter, how many converter clocks each conversion lasts, and how a conversion begins. A conversion can begin on a software command, on a chosen edge of one of five external trigger lines, or continuously in a scanning mode that walks the selected inputs in ascending order.

Each input has its own result word, and a shared result word always holds the most recent conversion together with the input it came from. Every result word carries a done flag and an overrun flag, and a read of a result word clears its flags. An interrupt line is raised either by any enabled input's done flag or only by the shared done flag. The analog converter is stood in for by a behavioural model. It samples a digital input word, waits the programmed number of converter clocks and returns the value cut to the programmed resolution.

The word addresses are: 0 control, 1 shared result, 2 interrupt enable, 3 status, and 8 plus n for the result of input n. Read data is combinational on the address. A clearing read takes effect at the clock edge where rd_en is high.

Top module: `adc_scan_ctrl`

## Requirements
- R1: The control word holds the input mask in bits 7:0, the divisor in 15:8, scan mode in 16, the length code in 19:17, the enable in 21, the start source in 26:24 and the falling-edge select in 27. The enable word holds bits 8:0. Both read back with all other bits zero.
- R2: While a conversion runs, the converter clock ticks once every divisor+1 system clocks. A software start written at edge E0 sets the done flag at edge E0 + 1 + N·(divisor+1), where N = 11 − length code.
- R3: The result keeps the upper 10 − code bits of the sampled 10-bit input, and its lower code bits read as zero.
- R4: Start source 1 written without scan mode converts the lowest selected input exactly once.
- R5: Start sources 2 to 6 start one conversion on an edge of trigger line source−2. The edge is rising when bit 27 is 0 and falling when it is 1. The other lines and the opposite edge have no effect.
- R6: In scan mode, conversions run back to back over the selected inputs in ascending order and wrap to the lowest one. The start source is ignored in this mode.
- R7: A result word holds the value in bits 15:6, overrun in bit 30 and done in bit 31, with bits 5:0 zero. The shared word also reports the input number in bits 26:24.
- R8: A completion on a word whose done flag is still set also sets that word's overrun flag.
- R9: Reading a result word clears its done and overrun flags. If a completion lands in the same cycle as the read, the new result is stored with done set and overrun clear.
- R10: With enable bit 8 clear, irq is the OR of the done flags gated by enable bits 7:0. With bit 8 set, irq equals the shared done flag.
- R11: The status word reports the done flags in bits 7:0, the overrun flags in 15:8 and irq in bit 16.
- R12: With the enable bit (21) clear, no conversion starts, and a running conversion is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the flags of result words) |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| trig | input | 5 | External trigger lines (asynchronous) |
| ain | input | 80 | Stand-in analog inputs, 10 bits per input, input n at bits 10n+9:10n |
| irq | output | 1 | Interrupt request |

## Verification
A clearing read of a result word and a fresh completion on that same word can fall into one cycle. The bench provokes this by first leaving a result unread. It then starts a second conversion on that input and times a read of it to the exact edge where the result is stored, which it works out from the formula in R2. It judges the outcome by reading the word back afterwards: done must be set and overrun clear, where the same scenario without the read must report overrun.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int NCH    = 8;
    localparam int RES    = 10;
    localparam int DIVW   = 8;
    localparam int NTRIG  = 5;
    localparam int CHW    = $clog2(NCH);
    localparam int MAXCLK = RES + 1;
    localparam int CNTW   = $clog2(MAXCLK + 1);

    localparam logic [3:0] A_CTRL  = 4'd0;
    localparam logic [3:0] A_GLOB  = 4'd1;
    localparam logic [3:0] A_INTEN = 4'd2;
    localparam logic [3:0] A_STAT  = 4'd3;

    // next selected input above 'after', wrapping to the lowest selected one
    function automatic logic [CHW-1:0] pick_next(input logic [NCH-1:0] m,
                                                 input logic [CHW-1:0] after);
        logic found;
        pick_next = '0;
        found     = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i] && (i > int'(after))) begin
                pick_next = CHW'(i);
                found     = 1'b1;
            end
        end
        if (!found) begin
            for (int i = NCH - 1; i >= 0; i--) begin
                if (m[i]) pick_next = CHW'(i);
            end
        end
    endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            clr,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == div);
        cnt_d = cnt_q + 1'b1;
        if (clr || !en || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int NTRIG = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] trig,
    output logic [NTRIG-1:0] rise,
    output logic [NTRIG-1:0] fall
);
    for (genvar g = 0; g < NTRIG; g++) begin : g_line
        logic [2:0] sh_d, sh_q;   // [0],[1] synchronizer, [2] previous value

        always_comb begin
            sh_d    = {sh_q[1:0], trig[g]};
            rise[g] = sh_q[1] && !sh_q[2];
            fall[g] = !sh_q[1] && sh_q[2];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end
    end
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               start,
    input  logic [CHW-1:0]     ch,
    input  logic [2:0]         code,
    input  logic               tick,
    input  logic [NCH*RES-1:0] ain,
    output logic               busy,
    output logic               done,
    output logic [RES-1:0]     value
);
    typedef struct packed {
        logic            busy;
        logic [CNTW-1:0] cnt;
        logic [RES-1:0]  smp;
        logic [2:0]      code;
    } stub_t;

    stub_t d, q;

    always_comb begin
        d     = q;
        done  = en && q.busy && tick && (q.cnt == CNTW'(1));
        busy  = q.busy;
        value = q.smp & ({RES{1'b1}} << q.code);
        if (!en) begin
            d.busy = 1'b0;
        end else if (start) begin
            d.busy = 1'b1;
            d.cnt  = CNTW'(MAXCLK) - CNTW'(code);
            d.smp  = ain[ch*RES +: RES];
            d.code = code;
        end else if (q.busy && tick) begin
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNTW'(1)) d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [3:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NTRIG-1:0]   trig,
    input  logic [NCH*RES-1:0] ain,
    output logic               irq
);
    typedef struct packed {
        logic [NCH-1:0]          mask;
        logic [DIVW-1:0]         div;
        logic                    burst;
        logic [2:0]              code;
        logic                    pdn;
        logic [2:0]              src;
        logic                    fall;
        logic                    sw_req;
        logic [NCH:0]            inten;
        logic [NCH-1:0][RES-1:0] ch_val;
        logic [NCH-1:0]          ch_done;
        logic [NCH-1:0]          ch_ovr;
        logic [RES-1:0]          g_val;
        logic [CHW-1:0]          g_ch;
        logic                    g_done;
        logic                    g_ovr;
        logic [CHW-1:0]          cur_ch;
        logic [CHW-1:0]          last_ch;
    } st_t;

    st_t d, q;

    logic [NTRIG-1:0] trig_rise, trig_fall;
    logic             tick, conv_busy, conv_done, start_go, trig_hit;
    logic [RES-1:0]   conv_val;
    logic [CHW-1:0]   next_ch;
    logic             unused_bits;

    assign unused_bits = ^{wdata[31:28], wdata[23:22], wdata[20]};

    adc_trig_sync #(.NTRIG(NTRIG)) u_sync (
        .clk(clk), .rst_n(rst_n), .trig(trig), .rise(trig_rise), .fall(trig_fall)
    );

    adc_clk_div #(.DIVW(DIVW)) u_div (
        .clk(clk), .rst_n(rst_n), .en(q.pdn), .clr(start_go), .div(q.div), .tick(tick)
    );

    adc_conv_stub u_conv (
        .clk(clk), .rst_n(rst_n), .en(q.pdn), .start(start_go), .ch(next_ch),
        .code(q.code), .tick(tick), .ain(ain),
        .busy(conv_busy), .done(conv_done), .value(conv_val)
    );

    always_comb begin
        d        = q;
        d.sw_req = 1'b0;

        // start selection
        trig_hit = 1'b0;
        for (int i = 0; i < NTRIG; i++) begin
            if (q.src == 3'(i + 2)) trig_hit = q.fall ? trig_fall[i] : trig_rise[i];
        end
        next_ch  = q.burst ? pick_next(q.mask, q.last_ch) : pick_next(q.mask, CHW'(NCH - 1));
        start_go = q.pdn && (q.mask != '0) && !conv_busy &&
                   (q.burst || q.sw_req || trig_hit);
        if (start_go) begin
            d.cur_ch = next_ch;
            if (q.burst) d.last_ch = next_ch;
        end

        // register writes
        if (wr_en && addr == A_CTRL) begin
            d.mask    = wdata[7:0];
            d.div     = wdata[15:8];
            d.burst   = wdata[16];
            d.code    = wdata[19:17];
            d.pdn     = wdata[21];
            d.src     = wdata[26:24];
            d.fall    = wdata[27];
            d.sw_req  = (wdata[26:24] == 3'd1);
            d.last_ch = CHW'(NCH - 1);
        end
        if (wr_en && addr == A_INTEN) d.inten = wdata[NCH:0];

        // clearing reads
        if (rd_en && addr == A_GLOB) begin
            d.g_done = 1'b0;
            d.g_ovr  = 1'b0;
        end
        if (rd_en && addr[3]) begin
            d.ch_done[addr[CHW-1:0]] = 1'b0;
            d.ch_ovr[addr[CHW-1:0]]  = 1'b0;
        end

        // completion wins over a clearing read in the same cycle
        if (conv_done) begin
            d.ch_ovr[q.cur_ch]  = d.ch_done[q.cur_ch];
            d.ch_done[q.cur_ch] = 1'b1;
            d.ch_val[q.cur_ch]  = conv_val;
            d.g_ovr             = d.g_done;
            d.g_done            = 1'b1;
            d.g_val             = conv_val;
            d.g_ch              = q.cur_ch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.last_ch <= CHW'(NCH - 1);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        irq = q.inten[NCH] ? q.g_done : |(q.ch_done & q.inten[NCH-1:0]);
        case (addr)
            A_CTRL:  rdata = {4'b0, q.fall, q.src, 2'b0, q.pdn, 1'b0, q.code,
                              q.burst, q.div, q.mask};
            A_GLOB:  rdata = {q.g_done, q.g_ovr, 3'b0, q.g_ch, 8'b0, q.g_val, 6'b0};
            A_INTEN: rdata = {23'b0, q.inten};
            A_STAT:  rdata = {15'b0, irq, q.ch_ovr, q.ch_done};
            default: rdata = addr[3] ? {q.ch_done[addr[CHW-1:0]], q.ch_ovr[addr[CHW-1:0]],
                                        14'b0, q.ch_val[addr[CHW-1:0]], 6'b0} : 32'b0;
        endcase
    end
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk
    import adc_seq_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         rd_en,
    input logic [3:0]   addr,
    input logic         irq,
    input logic         conv_done,
    input logic         conv_busy,
    input logic         pdn,
    input logic         g_done,
    input logic         g_ovr,
    input logic [NCH:0] inten
);
    AST_GDONE_FROM_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_done) |-> $past(conv_done)); // R7
    AST_OVR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        g_ovr |-> g_done); // R8
    AST_GREAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_GLOB && !conv_done) |=> !g_done); // R9
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn |=> !conv_busy); // R12
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (inten == '0) |-> !irq); // R10
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_busy); // R2
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .irq(irq),
    .conv_done(conv_done), .conv_busy(conv_busy), .pdn(q.pdn),
    .g_done(q.g_done), .g_ovr(q.g_ovr), .inten(q.inten)
);

// File: tb/sim_adc_scan_ctrl.sv
module sim_adc_scan_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  trig = '0;
    logic [79:0] ain;
    logic        irq;
    int          errors = 0, checks = 0, cycles = 0;

    always #2 clk = ~clk;

    adc_scan_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .trig(trig), .ain(ain), .irq(irq));

    function automatic logic [9:0] ain_of(input int ch);
        return 10'((ch * 83 + 301) % 1024);
    endfunction

    function automatic logic [31:0] mk(input logic [7:0] m, input logic [7:0] dv,
        input logic bu, input logic [2:0] cd, input logic pd, input logic [2:0] sr,
        input logic fe);
        return {4'b0, fe, sr, 2'b0, pd, 1'b0, cd, bu, dv, m};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] v);
        addr = a; #1 v = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_stat(input int bitn);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            peek(4'd3, v);
            if (v[bitn]) break;
            @(negedge clk);
        end
    endtask

    task automatic clear_all();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) rd(4'(8 + i), v);
        rd(4'd1, v);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, w;
        int seq[6];
        for (int i = 0; i < 8; i++) ain[i*10 +: 10] = ain_of(i);
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // reset state
        peek(4'd3, v); chk(v == 0 && irq == 0, "R11 reset status", v, 0);
        peek(4'd0, v); chk(v == 0, "R1 reset ctrl", v, 0);

        // R1 readback of defined bits only (enable bit clear)
        wr(4'd0, 32'hFFDF_FFFF);
        rd(4'd0, v); chk(v == 32'h0F0F_FFFF, "R1 ctrl readback", v, 32'h0F0F_FFFF);
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, v); chk(v == 32'h0000_01FF, "R1 inten readback", v, 32'h1FF);
        wr(4'd2, 32'h0);
        wr(4'd0, 32'h0);

        // R3/R7 sweep over every length code and input
        for (int cd = 0; cd < 8; cd++) begin
            for (int ch = 0; ch < 8; ch++) begin
                logic [9:0] e;
                e = ain_of(ch) & (10'h3FF << cd);
                wr(4'd0, mk(8'(1 << ch), 8'd0, 1'b0, 3'(cd), 1'b1, 3'd1, 1'b0));
                wait_stat(ch);
                rd(4'(8 + ch), v);
                chk(v[15:6] == e, "R3 result value", {22'b0, v[15:6]}, {22'b0, e});
                chk(v[31] && !v[30] && v[5:0] == 0 && v[29:16] == 0, "R7 channel word",
                    v, {1'b1, 15'b0, e, 6'b0});
                rd(4'd1, v);
                chk(v[26:24] == 3'(ch) && v[15:6] == e && v[31], "R7 shared word", v,
                    {1'b1, 4'b0, 3'(ch), 8'b0, e, 6'b0});
            end
        end

        // R2 conversion timing for several divisors and codes
        for (int dv = 0; dv < 4; dv++) begin
            for (int k = 0; k < 2; k++) begin
                int n;
                n = (k == 0) ? 11 : 4;
                wr(4'd0, mk(8'h01, 8'(dv), 1'b0, 3'((k == 0) ? 0 : 7), 1'b1, 3'd1, 1'b0));
                addr = 4'd3;
                idle(n * (dv + 1));
                peek(4'd3, v); chk(v[0] == 1'b0, "R2 not yet done", v, 0);
                idle(1);
                peek(4'd3, v); chk(v[0] == 1'b1, "R2 done on time", v, 1);
                clear_all();
            end
        end

        // R4 lowest selected input, once
        wr(4'd0, mk(8'h60, 8'd0, 1'b0, 3'd7, 1'b1, 3'd1, 1'b0));
        wait_stat(5);
        idle(60);
        peek(4'd3, v); chk(v == 32'h20, "R4 single lowest input", v, 32'h20);
        clear_all();

        // R8 overrun, R11 status, R9 clearing read
        wr(4'd0, mk(8'h08, 8'd0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
        wait_stat(3);
        wr(4'd0, mk(8'h08, 8'd0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
        idle(20);
        peek(4'd3, v); chk(v == 32'h0808, "R11 status done+overrun", v, 32'h0808);
        rd(4'd11, v); chk(v[31] && v[30], "R8 overrun set", v, 32'hC000_0000);
        peek(4'd11, v); chk(!v[31] && !v[30], "R9 read clears", v, 0);
        rd(4'd1, v); chk(v[31] && v[30], "R8 shared overrun", v, 32'hC000_0000);
        peek(4'd1, v); chk(!v[31] && !v[30], "R9 shared read clears", v, 0);

        // R9 read landing on the completion edge
        wr(4'd0, mk(8'h08, 8'd0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
        wait_stat(3);
        idle(3);
        wr(4'd0, mk(8'h08, 8'd0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
        idle(11);
        addr = 4'd11; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        peek(4'd11, v); chk(v[31] && !v[30], "R9 completion beats read", v, 32'h8000_0000);
        clear_all();

        // R10 interrupt modes
        wr(4'd2, 32'h008);
        wr(4'd0, mk(8'h08, 8'd0, 1'b0, 3'd7, 1'b1, 3'd1, 1'b0));
        wait_stat(3); #1;
        chk(irq == 1'b1, "R10 enabled input irq", {31'b0, irq}, 1);
        rd(4'd11, v); #1;
        chk(irq == 1'b0, "R10 irq clears with read", {31'b0, irq}, 0);
        wr(4'd0, mk(8'h10, 8'd0, 1'b0, 3'd7, 1'b1, 3'd1, 1'b0));
        wait_stat(4); #1;
        chk(irq == 1'b0, "R10 masked input no irq", {31'b0, irq}, 0);
        wr(4'd2, 32'h100); #1;
        chk(irq == 1'b1, "R10 shared done irq", {31'b0, irq}, 1);
        rd(4'd1, v); #1;
        chk(irq == 1'b0, "R10 shared read drops irq", {31'b0, irq}, 0);
        clear_all();

        // R5 triggers: every source, both polarities
        wr(4'd2, 32'h0);
        for (int s = 0; s < 5; s++) begin
            for (int fe = 0; fe < 2; fe++) begin
                wr(4'd0, mk(8'h01, 8'd0, 1'b0, 3'd7, 1'b1, 3'(s + 2), 1'(fe)));
                if (fe == 0) begin
                    trig[(s + 1) % 5] = 1'b1; idle(3); trig[(s + 1) % 5] = 1'b0; idle(20);
                    peek(4'd3, v); chk(v[0] == 0, "R5 other line ignored", v, 0);
                    trig[s] = 1'b1; idle(3); trig[s] = 1'b0; idle(20);
                    peek(4'd3, v); chk(v[0] == 1, "R5 rising edge starts", v, 1);
                end else begin
                    trig[s] = 1'b1; idle(20);
                    peek(4'd3, v); chk(v[0] == 0, "R5 rising ignored when falling", v, 0);
                    trig[s] = 1'b0; idle(20);
                    peek(4'd3, v); chk(v[0] == 1, "R5 falling edge starts", v, 1);
                end
                clear_all();
            end
        end

        // R6 scan order with wrap; start source set to a trigger and ignored
        seq = '{1, 2, 5, 7, 1, 2};
        wr(4'd2, 32'h100);
        wr(4'd0, mk(8'hA6, 8'd7, 1'b1, 3'd7, 1'b1, 3'd2, 1'b0));
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 500; i++) begin
                if (irq) break;
                @(negedge clk);
            end
            rd(4'd1, v);
            chk(v[31] && v[26:24] == 3'(seq[k]), "R6 scan order", {29'b0, v[26:24]},
                32'(seq[k]));
        end
        wr(4'd0, 32'h0);
        idle(5);
        clear_all();
        wr(4'd2, 32'h0);

        // R12 disabled converter does nothing
        wr(4'd0, mk(8'h01, 8'd0, 1'b0, 3'd7, 1'b0, 3'd1, 1'b0));
        idle(50);
        peek(4'd3, v); chk(v == 0, "R12 no start when off", v, 0);
        peek(4'd1, w); chk(w[31] == 0, "R12 shared idle when off", w, 0);
        // abandon a running conversion
        wr(4'd0, mk(8'h01, 8'd3, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
        idle(10);
        wr(4'd0, mk(8'h01, 8'd3, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0));
        idle(80);
        peek(4'd3, v); chk(v == 0, "R12 running conversion abandoned", v, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule